// File: doc/BRIEF.md
# Network Controller Reset Sequencer with Register Defaults

This block owns the control and status register bank of a network controller and applies its two reset modes to it. A hardware reset comes from an asynchronous pin. It is accepted only when the pin stays asserted for at least a minimum number of periods of both the bus clock and the transmit clock, so the slower of the two sets the required pulse length. The pulse length is measured in the bus clock domain. The transmit clock is synchronized into that domain and its rising edges are counted. A pulse shorter than the minimum leaves every register as it was.

An accepted hardware reset loads fixed values into some registers and clears only selected fields of the configuration and receive-control registers. All other fields keep their contents. A software reset is requested by writing the command register with its reset bit set. It reloads only the command register, and the reset bit then clears itself one bus clock later. A plain write port lets the surrounding logic load any register. The bank is visible as one output per register.

Top module: `nic_rst_ctl`

## Requirements
- R1: A hardware reset takes effect only when the pin stays asserted for at least MIN_PULSE (default 10) bus clock periods and MIN_PULSE transmit clock periods. A shorter pulse changes no register.
- R2: An accepted hardware reset sets the command register to 0x0094, the transmit control register to 0x0101 and the end-of-buffer count register to 0x02F8.
- R3: An accepted hardware reset clears the interrupt mask, interrupt status, packet sequence, buffer sequence and CAM enable registers to 0x0000.
- R4: An accepted hardware reset clears bits 15 and 13 of the data configuration register and bits 4..0 of the second configuration register, and leaves every other bit of both registers unchanged.
- R5: An accepted hardware reset clears receive control bits 10..9 (loopback select) and bit 13 (broadcast accept), and leaves every other bit of that register unchanged.
- R6: A write to address 0 with data bit 7 set is a software reset. One clock later the command register reads 0x00A4 and every other register is unchanged.
- R7: One clock after the software reset value is loaded, command bit 7 clears on its own, so the command register reads 0x0024.
- R8: While an accepted hardware reset is held (pin still asserted), writes have no effect.
- R9: The write port updates the addressed register one clock after wr_en, using this map: 0 command, 1 data configuration, 2 second configuration, 3 interrupt mask, 4 interrupt status, 5 transmit control, 6 receive control, 7 end-of-buffer count, 8 packet sequence, 9 buffer sequence, 10 CAM enable. Addresses 11..15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock; all registers run on its rising edge |
| clk_tx | input | 1 | Transmit clock; only synchronized and edge-counted |
| hw_rst_pin | input | 1 | Asynchronous hardware reset request, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Write data |
| cmd_q | output | 16 | Command register |
| dcr_q | output | 16 | Data configuration register |
| dcr2_q | output | 16 | Second configuration register |
| imr_q | output | 16 | Interrupt mask register |
| isr_q | output | 16 | Interrupt status register |
| tcr_q | output | 16 | Transmit control register |
| rcr_q | output | 16 | Receive control register |
| eobc_q | output | 16 | End-of-buffer count register |
| pkt_seq_q | output | 16 | Packet sequence counter |
| buf_seq_q | output | 16 | Buffer sequence counter |
| cam_en_q | output | 16 | CAM enable register |

## Verification
The assertions assume that the transmit clock runs at less than half the bus clock rate, so each of its edges is sampled at least once. They check nothing until the first accepted hardware reset, because the bank holds no defined value before that. The stimulus keeps the transmit period at five bus periods. It drives the pin, the write strobe, the address and the data only on falling bus clock edges. Hardware pulses are either clearly too short (four transmit periods) or clearly long enough (fifteen), so no result depends on where the synchronizers happen to sample.

// File: rtl/nic_rst_pkg.sv
package nic_rst_pkg;
   localparam int REG_W    = 16;
   localparam int NREG     = 11;
   localparam int IDX_CMD  = 0;
   localparam int IDX_DCR  = 1;
   localparam int IDX_DCR2 = 2;
   localparam int IDX_IMR  = 3;
   localparam int IDX_ISR  = 4;
   localparam int IDX_TCR  = 5;
   localparam int IDX_RCR  = 6;
   localparam int IDX_EOBC = 7;
   localparam int IDX_PSEQ = 8;
   localparam int IDX_BSEQ = 9;
   localparam int IDX_CAM  = 10;
   localparam int RST_BIT  = 7;
   localparam logic [REG_W-1:0] CMD_SW_VAL = 16'h00A4;

   // bits forced by a hardware reset
   function automatic logic [REG_W-1:0] hw_mask(int idx);
      case (idx)
         IDX_DCR:  return 16'hA000;
         IDX_DCR2: return 16'h001F;
         IDX_RCR:  return 16'h2600;
         default:  return 16'hFFFF;
      endcase
   endfunction

   // value taken by the forced bits
   function automatic logic [REG_W-1:0] hw_val(int idx);
      case (idx)
         IDX_CMD:  return 16'h0094;
         IDX_TCR:  return 16'h0101;
         IDX_EOBC: return 16'h02F8;
         default:  return 16'h0000;
      endcase
   endfunction
endpackage

// File: rtl/nic_rst_sync.sv
module nic_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/nic_rst_qual.sv
module nic_rst_qual #(
   parameter int MIN_PULSE   = 10,
   parameter int SYNC_STAGES = 2,
   parameter bit TX_QUAL     = 1'b1
) (
   input  logic clk,
   input  logic pin_async,
   input  logic tx_clk_async,
   output logic hw_go
);
   localparam int CNT_W = $clog2(MIN_PULSE + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);

   logic             pin_s;
   logic [CNT_W-1:0] bus_cnt;
   logic             bus_done;
   logic             tx_done;

   nic_rst_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .d(pin_async), .q(pin_s)
   );

   always_ff @(posedge clk) begin
      if (!pin_s)         bus_cnt <= '0;
      else if (!bus_done) bus_cnt <= bus_cnt + 1'b1;
   end
   assign bus_done = (bus_cnt == CNT_MAX);

   generate
      if (TX_QUAL) begin : g_tx_count
         logic             tx_s;
         logic             tx_d;
         logic [CNT_W-1:0] tx_cnt;

         nic_rst_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
            .clk(clk), .d(tx_clk_async), .q(tx_s)
         );

         always_ff @(posedge clk) begin
            tx_d <= tx_s;
            if (!pin_s)                            tx_cnt <= '0;
            else if (tx_s && !tx_d && !tx_done)    tx_cnt <= tx_cnt + 1'b1;
         end
         assign tx_done = (tx_cnt == CNT_MAX);
      end else begin : g_bus_only
         assign tx_done = 1'b1;
      end
   endgenerate

   assign hw_go = pin_s & bus_done & tx_done;
endmodule

// File: rtl/nic_rst_regfile.sv
module nic_rst_regfile
   import nic_rst_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic                        clk,
   input  logic                        hw_go,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [REG_W-1:0]            wr_data,
   output logic [NREG-1:0][REG_W-1:0]  q
);
   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         localparam logic [REG_W-1:0] M = hw_mask(i);
         localparam logic [REG_W-1:0] V = hw_val(i);
         logic hit;
         assign hit = wr_en && (wr_addr == ADDR_W'(i));

         if (i == IDX_CMD) begin : g_cmd
            logic clr_pend;
            always_ff @(posedge clk) begin
               if (hw_go) begin
                  q[i]     <= (q[i] & ~M) | (V & M);
                  clr_pend <= 1'b0;
               end else if (hit && wr_data[RST_BIT]) begin
                  q[i]     <= CMD_SW_VAL;
                  clr_pend <= 1'b1;
               end else if (hit) begin
                  q[i]     <= wr_data;
                  clr_pend <= 1'b0;
               end else if (clr_pend) begin
                  q[i][RST_BIT] <= 1'b0;
                  clr_pend      <= 1'b0;
               end
            end
         end else begin : g_plain
            always_ff @(posedge clk) begin
               if (hw_go)    q[i] <= (q[i] & ~M) | (V & M);
               else if (hit) q[i] <= wr_data;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/nic_rst_ctl.sv
module nic_rst_ctl
   import nic_rst_pkg::*;
#(
   parameter int MIN_PULSE   = 10,
   parameter int SYNC_STAGES = 2,
   parameter bit TX_QUAL     = 1'b1,
   parameter int ADDR_W      = 4
) (
   input  logic              clk_bus,
   input  logic              clk_tx,
   input  logic              hw_rst_pin,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   output logic [15:0]       cmd_q,
   output logic [15:0]       dcr_q,
   output logic [15:0]       dcr2_q,
   output logic [15:0]       imr_q,
   output logic [15:0]       isr_q,
   output logic [15:0]       tcr_q,
   output logic [15:0]       rcr_q,
   output logic [15:0]       eobc_q,
   output logic [15:0]       pkt_seq_q,
   output logic [15:0]       buf_seq_q,
   output logic [15:0]       cam_en_q
);
   generate
      if (MIN_PULSE < 1)       begin : g_bad_min   $error("MIN_PULSE must be at least 1");   end
      if (SYNC_STAGES < 2)     begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
      if ((1 << ADDR_W) < NREG) begin : g_bad_addr $error("ADDR_W too small for the bank");  end
   endgenerate

   logic                       hw_go;
   logic [NREG-1:0][REG_W-1:0] bank;

   nic_rst_qual #(
      .MIN_PULSE(MIN_PULSE), .SYNC_STAGES(SYNC_STAGES), .TX_QUAL(TX_QUAL)
   ) u_qual (
      .clk(clk_bus), .pin_async(hw_rst_pin), .tx_clk_async(clk_tx), .hw_go(hw_go)
   );

   nic_rst_regfile #(.ADDR_W(ADDR_W)) u_bank (
      .clk(clk_bus), .hw_go(hw_go), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .q(bank)
   );

   assign cmd_q     = bank[IDX_CMD];
   assign dcr_q     = bank[IDX_DCR];
   assign dcr2_q    = bank[IDX_DCR2];
   assign imr_q     = bank[IDX_IMR];
   assign isr_q     = bank[IDX_ISR];
   assign tcr_q     = bank[IDX_TCR];
   assign rcr_q     = bank[IDX_RCR];
   assign eobc_q    = bank[IDX_EOBC];
   assign pkt_seq_q = bank[IDX_PSEQ];
   assign buf_seq_q = bank[IDX_BSEQ];
   assign cam_en_q  = bank[IDX_CAM];
endmodule

// File: rtl/nic_rst_chk.sv
module nic_rst_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              hw_go,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [15:0]       wr_data,
   input logic [15:0]       cmd_q,
   input logic [15:0]       dcr_q,
   input logic [15:0]       dcr2_q,
   input logic [15:0]       imr_q,
   input logic [15:0]       isr_q,
   input logic [15:0]       tcr_q,
   input logic [15:0]       rcr_q,
   input logic [15:0]       eobc_q,
   input logic [15:0]       cam_en_q
);
   logic armed = 1'b0;
   logic sw_fire;
   logic cmd_hit;

   always_ff @(posedge clk) begin
      if (hw_go === 1'b1) armed <= 1'b1;
   end

   assign cmd_hit = wr_en && (wr_addr == '0);
   assign sw_fire = cmd_hit && wr_data[7];

   AST_HW_LOADS: assert property (@(posedge clk) disable iff (!armed)
      hw_go |=> (cmd_q == 16'h0094 && tcr_q == 16'h0101 && eobc_q == 16'h02F8)); // R2
   AST_HW_CLEARS: assert property (@(posedge clk) disable iff (!armed)
      hw_go |=> (imr_q == 16'h0 && isr_q == 16'h0 && cam_en_q == 16'h0)); // R3
   AST_CFG_PARTIAL: assert property (@(posedge clk) disable iff (!armed)
      hw_go |=> ((dcr_q & 16'h5FFF) == ($past(dcr_q) & 16'h5FFF) && dcr_q[15] == 1'b0
                 && dcr_q[13] == 1'b0 && dcr2_q[4:0] == 5'h0
                 && dcr2_q[15:5] == $past(dcr2_q[15:5]))); // R4
   AST_RCR_PARTIAL: assert property (@(posedge clk) disable iff (!armed)
      hw_go |=> ((rcr_q & 16'hD9FF) == ($past(rcr_q) & 16'hD9FF) && (rcr_q & 16'h2600) == 16'h0)); // R5
   AST_SW_ONLY_CMD: assert property (@(posedge clk) disable iff (!armed)
      (sw_fire && !hw_go) |=> (cmd_q == 16'hA4 && $stable(dcr_q) && $stable(tcr_q)
                               && $stable(imr_q) && $stable(eobc_q))); // R6
   AST_SW_SELF_CLEAR: assert property (@(posedge clk) disable iff (!armed)
      ($past(sw_fire && !hw_go) && !hw_go && !cmd_hit) |=> (cmd_q == 16'h0024)); // R7
   AST_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (!armed)
      (hw_go && $past(hw_go)) |=> $stable(imr_q)); // R8
endmodule

bind nic_rst_ctl nic_rst_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk_bus), .hw_go(hw_go), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .cmd_q(cmd_q), .dcr_q(dcr_q), .dcr2_q(dcr2_q), .imr_q(imr_q), .isr_q(isr_q),
   .tcr_q(tcr_q), .rcr_q(rcr_q), .eobc_q(eobc_q), .cam_en_q(cam_en_q)
);

// File: tb/nic_rst_ctl_tb_top.sv
module nic_rst_ctl_tb_top;
   logic        clk_bus = 1'b0;
   logic        clk_tx  = 1'b0;
   logic        hw_rst_pin = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] cmd_q, dcr_q, dcr2_q, imr_q, isr_q, tcr_q, rcr_q, eobc_q;
   logic [15:0] pkt_seq_q, buf_seq_q, cam_en_q;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [15:0] exp_r [11];

   always #4  clk_bus = ~clk_bus;   // 125 MHz
   always #20 clk_tx  = ~clk_tx;    // five bus periods

   nic_rst_ctl dut_i (
      .clk_bus(clk_bus), .clk_tx(clk_tx), .hw_rst_pin(hw_rst_pin),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cmd_q(cmd_q), .dcr_q(dcr_q), .dcr2_q(dcr2_q), .imr_q(imr_q), .isr_q(isr_q),
      .tcr_q(tcr_q), .rcr_q(rcr_q), .eobc_q(eobc_q), .pkt_seq_q(pkt_seq_q),
      .buf_seq_q(buf_seq_q), .cam_en_q(cam_en_q)
   );

   function automatic logic [15:0] actual(int i);
      case (i)
         0: return cmd_q;     1: return dcr_q;     2: return dcr2_q;
         3: return imr_q;     4: return isr_q;     5: return tcr_q;
         6: return rcr_q;     7: return eobc_q;    8: return pkt_seq_q;
         9: return buf_seq_q; default: return cam_en_q;
      endcase
   endfunction

   // forced bits and values of an accepted hardware reset (R2..R5)
   function automatic logic [15:0] fmask(int i);
      case (i)
         1: return 16'hA000; 2: return 16'h001F; 6: return 16'h2600;
         default: return 16'hFFFF;
      endcase
   endfunction
   function automatic logic [15:0] fval(int i);
      case (i)
         0: return 16'h0094; 5: return 16'h0101; 7: return 16'h02F8;
         default: return 16'h0000;
      endcase
   endfunction
   function automatic string tag_of(int i);
      case (i)
         0, 5, 7: return "R2";
         1, 2: return "R4";
         6: return "R5";
         default: return "R3";
      endcase
   endfunction

   task automatic check(string req, int i, logic [15:0] exp);
      checks++;
      if (actual(i) !== exp) begin
         fails++;
         $display("FAIL %s reg%0d actual=%h expected=%h", req, i, actual(i), exp);
      end
   endtask

   task automatic check_all(string req);
      for (int i = 0; i < 11; i++) check(req, i, exp_r[i]);
   endtask

   task automatic model_hw();
      for (int i = 0; i < 11; i++) exp_r[i] = (exp_r[i] & ~fmask(i)) | (fval(i) & fmask(i));
   endtask

   task automatic do_write(logic [3:0] a, logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk_bus);
      wr_en = 1'b0;
   endtask

   // pin held for a number of transmit periods; optional write while held
   task automatic pulse(int tx_periods, bit write_mid);
      hw_rst_pin = 1'b1;
      repeat (tx_periods * 5 - 10) @(negedge clk_bus);
      if (write_mid) do_write(4'd3, 16'hBEEF);
      else @(negedge clk_bus);
      repeat (9) @(negedge clk_bus);
      hw_rst_pin = 1'b0;
      repeat (6) @(negedge clk_bus);
   endtask

   initial begin
      process::self().srandom(32'h5EED_1234);
      repeat (5) @(negedge clk_bus);
      // load known contents first (R9)
      for (int i = 0; i < 11; i++) begin
         exp_r[i] = 16'($urandom) & ((i == 0) ? 16'hFF7F : 16'hFFFF);
         do_write(4'(i), exp_r[i]);
      end
      check_all("R9");
      // accepted hardware reset: reset state (R1..R5)
      pulse(15, 1'b0);
      model_hw();
      for (int i = 0; i < 11; i++) check(tag_of(i), i, exp_r[i]);
      // directed: short pulse ignored (R1)
      pulse(4, 1'b0);
      check_all("R1");
      // directed: write during held reset ignored (R8)
      do_write(4'd3, 16'h1234); exp_r[3] = 16'h1234;
      pulse(15, 1'b1);
      model_hw();
      check("R8", 3, 16'h0000);
      check_all("R8");
      // directed: software reset and self-clear (R6, R7)
      do_write(4'd1, 16'hFFFF); exp_r[1] = 16'hFFFF;
      do_write(4'd0, 16'h0080);
      exp_r[0] = 16'h00A4;
      check_all("R6");
      @(negedge clk_bus);
      exp_r[0] = 16'h0024;
      check("R7", 0, 16'h0024);
      // directed: unmapped address ignored (R9)
      do_write(4'd12, 16'hFFFF);
      check_all("R9");
      // random mix
      for (int n = 0; n < 60; n++) begin
         int op = $urandom_range(0, 9);
         if (op < 6) begin
            logic [3:0]  a = 4'($urandom_range(0, 15));
            logic [15:0] d = 16'($urandom);
            if (a == 0) d[7] = 1'b0;
            do_write(a, d);
            if (a < 11) exp_r[a] = d;
            check_all("R9");
         end else if (op < 8) begin
            do_write(4'd0, 16'($urandom) | 16'h0080);
            exp_r[0] = 16'h00A4;
            check_all("R6");
            @(negedge clk_bus);
            exp_r[0] = 16'h0024;
            check_all("R7");
         end else if (op == 8) begin
            pulse(4, 1'b0);
            check_all("R1");
         end else begin
            pulse(15, 1'b0);
            model_hw();
            check_all("R1");
         end
      end
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule